// File: doc/BRIEF.md
# Compacted State-Save Layout Sequencer

This block plans the memory layout of one compacted save of extended processor state. A start pulse captures a 64-bit request mask, a 64-bit enable mask, a 64-bit in-use bitmap and the vector unit's 32-bit control/status word. From these the block derives two sets. The requested set is the AND of the request and enable masks. The stored set is the requested set ANDed with the in-use bitmap, plus one exception for component 1.

The block then walks the component indices 0 to 62 in ascending order, one index per clock. For every component it stores, it sends a (component index, byte offset, legacy flag) command over a valid/ready handshake. Components 0 and 1 live in the fixed legacy region. Every later requested component takes the next packed slot of the compacted region, and that slot is reserved even when the component is not stored. Once the last command has been taken, the block pulses `done` and presents the two header words. A memory-write engine downstream consumes the commands and the header words.

The per-component size table comes in on a flat port and must stay stable for the whole save.

Top module: `csave_layout_seq`

## Requirements
- R1: The requested set is `req_mask & enable_mask`, captured on an accepted start. At `done`, `hdr_compact` equals the requested set with bit 63 forced to 1.
- R2: Component i is marked for storing when its requested bit and its in-use bit are both 1. At `done`, `hdr_state` equals the marked set, so a requested component that is not in use reads 0.
- R3: Component 1 is also marked when its requested bit is 1 and `vec_csr` differs from 0x1F80, even if its in-use bit is 0. With `vec_csr` equal to 0x1F80, or with bit 1 not requested, no forcing happens.
- R4: A marked component 0 or 1 produces one command with `cmd_legacy`=1 and `cmd_offset`=0. Such commands come before any command for a component of index 2 or higher.
- R5: Compacted offsets start at 576. For i from 2 to 62 ascending, each requested component adds `comp_sizes[i*32 +: 32]` to the running offset, whether or not it is stored. A stored component's command (`cmd_legacy`=0) carries the offset as it stood before its own size was added.
- R6: Commands are issued only for marked components with index at most 62. Each such component gets exactly one command, in strictly ascending index order. Component 63 never gets a command.
- R7: While `cmd_valid`=1 and `cmd_ready`=0, `cmd_valid`, `cmd_index`, `cmd_offset` and `cmd_legacy` hold their values.
- R8: `done` is a one-cycle pulse. It rises on the clock edge at which the last command is accepted, or one scan step after the scan ends if no command is pending. The header words hold their values until the next `done`.
- R9: `busy` goes high in the cycle after an accepted start and falls together with the rising of `done`. A start while `busy`=1 is ignored.
- R10: After reset, `cmd_valid`, `done` and `busy` are 0 and both header words are 0.
- R11: The running offset is 32 bits wide and wraps modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a save plan (taken only when idle) |
| req_mask | input | 64 | Requested components for this save |
| enable_mask | input | 64 | Components enabled by the system |
| inuse_mask | input | 64 | Components currently holding non-initial state |
| vec_csr | input | 32 | Vector unit control/status word |
| comp_sizes | input | 2048 | Size in bytes of component i at bits [i*32 +: 32]; only 2..62 used |
| cmd_valid | output | 1 | Store command valid |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_index | output | 6 | Component index of the command |
| cmd_offset | output | 32 | Byte offset from the save area base (0 for legacy) |
| cmd_legacy | output | 1 | Command targets the fixed legacy region |
| busy | output | 1 | A save plan is in progress |
| done | output | 1 | One-cycle pulse: plan complete, headers valid |
| hdr_state | output | 64 | State bitmap header word |
| hdr_compact | output | 64 | Compaction bitmap header word |

## Verification
A wrong captured bitmap shows up in the first command or header word that depends on the corrupted bit. A wrong running offset shows up on the next compacted command after the point of corruption, and every later offset in that save is shifted by the same error. A wrong index or state register shows up as a missing, duplicated or out-of-order command, or as a `done` that comes early, late or never. All of these are visible within one save of about 64 cycles plus the stall cycles. Under back-pressure, a fault in the output register shows up in the very cycle after the stall begins.

// File: rtl/csave_pkg.sv
package csave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } csave_state_e;
endpackage

// File: rtl/csave_mask_calc.sv
module csave_mask_calc #(
  parameter int NCOMP     = 64,
  parameter int CSR_W     = 32,
  parameter logic [CSR_W-1:0] CSR_INIT = 32'h1F80,
  parameter int FORCE_IDX = 1
) (
  input  logic [NCOMP-1:0] req_mask,
  input  logic [NCOMP-1:0] enable_mask,
  input  logic [NCOMP-1:0] inuse_mask,
  input  logic [CSR_W-1:0] vec_csr,
  output logic [NCOMP-1:0] requested,
  output logic [NCOMP-1:0] to_store
);
  logic csr_dirty;

  assign csr_dirty = (vec_csr != CSR_INIT);

  always_comb begin
    requested = req_mask & enable_mask;
    to_store  = requested & inuse_mask;
    if (requested[FORCE_IDX] && csr_dirty)
      to_store[FORCE_IDX] = 1'b1;
  end
endmodule

// File: rtl/csave_size_sel.sv
module csave_size_sel #(
  parameter int NCOMP  = 64,
  parameter int SIZE_W = 32,
  localparam int IDX_W = $clog2(NCOMP)
) (
  input  logic [NCOMP*SIZE_W-1:0] sizes_flat,
  input  logic [IDX_W-1:0]        idx,
  output logic [SIZE_W-1:0]       size
);
  logic [SIZE_W-1:0] tbl [NCOMP];

  for (genvar g = 0; g < NCOMP; g++) begin : g_unpack
    assign tbl[g] = sizes_flat[g*SIZE_W +: SIZE_W];
  end

  assign size = tbl[idx];
endmodule

// File: rtl/csave_cmd_stage.sv
module csave_cmd_stage #(
  parameter int IDX_W = 6,
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             emit,
  input  logic [IDX_W-1:0] in_index,
  input  logic [OFF_W-1:0] in_offset,
  input  logic             in_legacy,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index,
  output logic [OFF_W-1:0] out_offset,
  output logic             out_legacy,
  output logic             free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_index  <= '0;
      out_offset <= '0;
      out_legacy <= 1'b0;
    end else if (step) begin
      out_valid <= emit;
      if (emit) begin
        out_index  <= in_index;
        out_offset <= in_offset;
        out_legacy <= in_legacy;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csave_layout_seq.sv
module csave_layout_seq #(
  parameter int NCOMP      = 64,
  parameter int SIZE_W     = 32,
  parameter int OFF_W      = 32,
  parameter int CSR_W      = 32,
  parameter int LEGACY_N   = 2,
  parameter int BASE_OFF   = 576,
  parameter logic [CSR_W-1:0] CSR_INIT = 32'h1F80,
  localparam int IDX_W = $clog2(NCOMP)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NCOMP-1:0]        req_mask,
  input  logic [NCOMP-1:0]        enable_mask,
  input  logic [NCOMP-1:0]        inuse_mask,
  input  logic [CSR_W-1:0]        vec_csr,
  input  logic [NCOMP*SIZE_W-1:0] comp_sizes,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [IDX_W-1:0]        cmd_index,
  output logic [OFF_W-1:0]        cmd_offset,
  output logic                    cmd_legacy,
  output logic                    busy,
  output logic                    done,
  output logic [NCOMP-1:0]        hdr_state,
  output logic [NCOMP-1:0]        hdr_compact
);
  import csave_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCOMP - 2);
  localparam logic [IDX_W-1:0] LEG_LIM  = IDX_W'(LEGACY_N);
  localparam logic [OFF_W-1:0] BASE     = OFF_W'(BASE_OFF);
  localparam logic [NCOMP-1:0] TOP_BIT  = {1'b1, {(NCOMP-1){1'b0}}};

  csave_state_e      state;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  run_off;
  logic [NCOMP-1:0]  req_q, store_q;
  logic [NCOMP-1:0]  req_c, store_c;
  logic [SIZE_W-1:0] cur_size;
  logic              free, step, emit, is_legacy;
  logic [OFF_W-1:0]  emit_off;

  csave_mask_calc #(
    .NCOMP(NCOMP), .CSR_W(CSR_W), .CSR_INIT(CSR_INIT), .FORCE_IDX(1)
  ) u_mask (
    .req_mask(req_mask), .enable_mask(enable_mask), .inuse_mask(inuse_mask),
    .vec_csr(vec_csr), .requested(req_c), .to_store(store_c)
  );

  csave_size_sel #(.NCOMP(NCOMP), .SIZE_W(SIZE_W)) u_size (
    .sizes_flat(comp_sizes), .idx(idx), .size(cur_size)
  );

  assign is_legacy = (idx < LEG_LIM);
  assign emit      = (state == ST_SCAN) && store_q[idx];
  assign emit_off  = is_legacy ? '0 : run_off;
  assign step      = free && (state == ST_SCAN || state == ST_DRAIN);

  csave_cmd_stage #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_cmd (
    .clk(clk), .rst(rst), .step(step), .emit(emit),
    .in_index(idx), .in_offset(emit_off), .in_legacy(is_legacy),
    .out_ready(cmd_ready), .out_valid(cmd_valid), .out_index(cmd_index),
    .out_offset(cmd_offset), .out_legacy(cmd_legacy), .free(free)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      run_off     <= '0;
      req_q       <= '0;
      store_q     <= '0;
      done        <= 1'b0;
      hdr_state   <= '0;
      hdr_compact <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            req_q   <= req_c;
            store_q <= store_c;
            idx     <= '0;
            run_off <= BASE;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (free) begin
            if (!is_legacy && req_q[idx])
              run_off <= run_off + OFF_W'(cur_size);
            if (idx == LAST_IDX)
              state <= ST_DRAIN;
            else
              idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (free) begin
            done        <= 1'b1;
            hdr_state   <= store_q;
            hdr_compact <= req_q | TOP_BIT;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csave_layout_chk.sv
module csave_layout_chk #(
  parameter int NCOMP = 64,
  parameter int OFF_W = 32,
  localparam int IDX_W = $clog2(NCOMP)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [IDX_W-1:0] cmd_index,
  input logic [OFF_W-1:0] cmd_offset,
  input logic             cmd_legacy,
  input logic [NCOMP-1:0] hdr_state,
  input logic [NCOMP-1:0] hdr_compact
);
  logic [IDX_W-1:0] last_idx;
  logic             have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_idx  <= '0;
      have_prev <= 1'b0;
    end else if (start && !busy) begin
      have_prev <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      last_idx  <= cmd_index;
      have_prev <= 1'b1;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) &&
      $stable(cmd_offset) && $stable(cmd_legacy));

  assert_legacy_zero_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_legacy |-> cmd_offset == '0 && cmd_index < IDX_W'(2));

  assert_compact_idx_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_legacy |-> cmd_index >= IDX_W'(2) &&
      cmd_index <= IDX_W'(NCOMP - 2));

  assert_ascending_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && have_prev |-> cmd_index > last_idx);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !cmd_valid);

  assert_top_bit_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> hdr_compact[NCOMP-1]);

  assert_subset_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (hdr_state & ~hdr_compact) == '0);
endmodule

bind csave_layout_seq csave_layout_chk #(.NCOMP(NCOMP), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
  .cmd_offset(cmd_offset), .cmd_legacy(cmd_legacy),
  .hdr_state(hdr_state), .hdr_compact(hdr_compact)
);

// File: tb/csave_layout_seq_test.sv
module csave_layout_seq_test;
  localparam int NC = 64;
  localparam int SW = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [NC-1:0]  req_mask = '0, enable_mask = '0, inuse_mask = '0;
  logic [31:0]    vec_csr = 32'h1F80;
  logic [NC*SW-1:0] comp_sizes = '0;
  logic           cmd_valid, cmd_ready = 1'b0, cmd_legacy, busy, done;
  logic [5:0]     cmd_index;
  logic [31:0]    cmd_offset;
  logic [NC-1:0]  hdr_state, hdr_compact;

  csave_layout_seq uut (
    .clk(clk), .rst(rst), .start(start), .req_mask(req_mask),
    .enable_mask(enable_mask), .inuse_mask(inuse_mask), .vec_csr(vec_csr),
    .comp_sizes(comp_sizes), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_offset(cmd_offset), .cmd_legacy(cmd_legacy),
    .busy(busy), .done(done), .hdr_state(hdr_state), .hdr_compact(hdr_compact)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [31:0] off_of3;

  int          exp_n;
  logic [5:0]  exp_idx [64];
  logic [31:0] exp_off [64];
  logic        exp_leg [64];

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_sizes(input int mode);
    for (int i = 0; i < NC; i++) begin
      if (mode == 0)      comp_sizes[i*SW +: SW] = 32'(64 + 16*i);
      else if (mode == 1) comp_sizes[i*SW +: SW] = (rnd() & 32'h0000_3FC0) + 32'd64;
      else                comp_sizes[i*SW +: SW] = (i == 2) ? 32'hFFFF_FF00 : 32'h100;
    end
  endtask

  task automatic run_save(input logic [63:0] rq, input logic [63:0] en,
                          input logic [63:0] iu, input logic [31:0] csr,
                          input bit rand_ready, input bit poke);
    logic [63:0] rf, sv;
    logic [31:0] off;
    int got, cyc;
    bit stalled, finished;
    logic [5:0] p_idx;
    logic [31:0] p_off;
    logic [63:0] h_s, h_c;
    rf = rq & en;
    sv = rf & iu;
    if (rf[1] && csr != 32'h1F80) sv[1] = 1'b1;
    exp_n = 0;
    off = 32'd576;
    for (int i = 0; i < 63; i++) begin
      if (i < 2) begin
        if (sv[i]) begin
          exp_idx[exp_n] = 6'(i); exp_off[exp_n] = '0; exp_leg[exp_n] = 1'b1; exp_n++;
        end
      end else if (rf[i]) begin
        if (sv[i]) begin
          exp_idx[exp_n] = 6'(i); exp_off[exp_n] = off; exp_leg[exp_n] = 1'b0; exp_n++;
        end
        off = off + comp_sizes[i*SW +: SW];
      end
    end
    req_mask = rq; enable_mask = en; inuse_mask = iu; vec_csr = csr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    got = 0; cyc = 0; stalled = 1'b0; finished = 1'b0; off_of3 = '0;
    p_idx = '0; p_off = '0;
    while (!finished) begin
      if (done) begin
        finished = 1'b1;
      end else begin
        if (stalled)
          check(cmd_valid && cmd_index == p_idx && cmd_offset == p_off, "R7",
                "held command", {cmd_index, cmd_offset}, {p_idx, p_off});
        cmd_ready = rand_ready ? rnd()[3] : 1'b1;
        if (cmd_valid && cmd_ready) begin
          if (cmd_index == 6'd3) off_of3 = cmd_offset;
          if (got < exp_n)
            check(cmd_index == exp_idx[got] && cmd_offset == exp_off[got] &&
                  cmd_legacy == exp_leg[got], exp_leg[got] ? "R4" : "R5",
                  "command idx/off/leg", {cmd_legacy, cmd_index, cmd_offset},
                  {exp_leg[got], exp_idx[got], exp_off[got]});
          else
            check(1'b0, "R6", "extra command", 64'(cmd_index), 64'd0);
          got++;
        end
        stalled = cmd_valid && !cmd_ready;
        p_idx = cmd_index; p_off = cmd_offset;
        if (poke && cyc == 10) begin
          start = 1'b1; req_mask = ~rq; enable_mask = '1; inuse_mask = '1;
          vec_csr = 32'h0;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        cyc++;
        if (cyc > 3000) begin
          check(1'b0, "R8", "done timeout", 64'(cyc), 64'd0);
          finished = 1'b1;
        end
      end
    end
    start = 1'b0;
    cmd_ready = 1'b0;
    check(got == exp_n, poke ? "R9" : "R6", "command count", 64'(got), 64'(exp_n));
    check(hdr_state == sv, "R2", "state header", hdr_state, sv);
    check(hdr_compact == (rf | 64'h8000_0000_0000_0000), "R1", "compaction header",
          hdr_compact, rf | 64'h8000_0000_0000_0000);
    check(hdr_state[1] == sv[1], "R3", "forced component 1", 64'(hdr_state[1]), 64'(sv[1]));
    check(busy == 1'b0, "R9", "busy at done", 64'(busy), 64'd0);
    h_s = hdr_state; h_c = hdr_compact;
    @(negedge clk);
    check(done == 1'b0 && hdr_state == h_s && hdr_compact == h_c, "R8",
          "done pulse width / header hold", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 global watchdog actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    load_sizes(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!cmd_valid && !done && !busy, "R10", "reset outputs",
          {61'd0, cmd_valid, done, busy}, 64'd0);
    check(hdr_state == '0 && hdr_compact == '0, "R10", "reset headers",
          hdr_state | hdr_compact, 64'd0);

    run_save('1, '1, '1, 32'h1F80, 1'b0, 1'b0);
    run_save('1, '1, '1, 32'h1F80, 1'b1, 1'b0);
    run_save('0, '1, '1, 32'h0, 1'b0, 1'b0);
    // R3: component 1 not in use, csr dirty -> forced
    run_save(64'h0000_0000_0000_00FF, '1, 64'h0000_0000_0000_00A9, 32'h0000_1F81, 1'b1, 1'b0);
    // R3: csr at reset value -> not forced
    run_save(64'h0000_0000_0000_00FF, '1, 64'h0000_0000_0000_00A9, 32'h0000_1F80, 1'b0, 1'b0);
    // R3: bit 1 masked by enable -> not forced
    run_save(64'h0000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0, 32'h0, 1'b0, 1'b0);
    // R6: only component 63 requested -> no commands
    run_save(64'h8000_0000_0000_0000, '1, '1, 32'h1F80, 1'b0, 1'b0);
    // R5: requested-but-unused components still advance offsets
    run_save(64'h4000_0000_0000_FFFC, '1, 64'h4000_0000_0000_8004, 32'h1F80, 1'b1, 1'b0);
    // R9: start while busy ignored
    run_save(64'h0F0F_0F0F_0F0F_0F0F, '1, 64'h00FF_00FF_00FF_00FF, 32'h1F80, 1'b1, 1'b1);
    // R11: offset wraps modulo 2^32
    load_sizes(2);
    run_save(64'h0000_0000_0000_000C, '1, '1, 32'h1F80, 1'b0, 1'b0);
    check(off_of3 == 32'h0000_0140, "R11", "wrapped offset", 64'(off_of3), 64'h140);

    for (int t = 0; t < 40; t++) begin
      logic [63:0] rq, en, iu;
      logic [31:0] csr;
      load_sizes(1);
      rq = {rnd(), rnd()};
      en = {rnd(), rnd()} | {rnd(), rnd()};
      iu = {rnd(), rnd()};
      csr = (t % 3 == 0) ? 32'h1F80 : rnd();
      run_save(rq, en, iu, csr, (t % 2) == 1, (t % 7) == 3);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule